// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block collects interrupt events for a USB peripheral controller and presents them to a host processor as one 32-bit status word and one interrupt line. Each endpoint buffer has its own receive and transmit event. Bus state changes also raise events: bus reset, resume, suspend, start-of-frame and pseudo start-of-frame. Each event sets a sticky status bit. Software clears a status bit by writing 1 to it. The interrupt line is a registered, active-high level. It is high whenever a status bit is set and its matching enable bit is also set.

The DMA engine has only one summary bit in the status word. Its individual causes are latched in a separate DMA reason register, which has its own enable register. Two small state machines do the sequencing:

- The summary machine has the states `SUM_IDLE` and `SUM_ACTIVE`.
  - Transition *arm*: `SUM_IDLE` moves to `SUM_ACTIVE` when any enabled reason bit is pending.
  - Transition *ack*: `SUM_ACTIVE` moves to `SUM_IDLE` when software writes 1 to the summary bit.
  - To clear the DMA condition for good, software first clears the reason bits and then the summary bit.
- The line machine has the states `LINE_LOW` and `LINE_HIGH`.
  - Transition *raise*: `LINE_LOW` moves to `LINE_HIGH` when the masked status is nonzero.
  - Transition *drop*: `LINE_HIGH` moves to `LINE_LOW` when the masked status is zero.

A simple register bus selects one of four registers with a 2-bit address:

| Address | Register |
|---|---|
| 0 | status |
| 1 | status enable |
| 2 | DMA reason |
| 3 | DMA reason enable |

Writes take effect at the clock edge. Reads are combinational.

Top module: `usb_irq_status`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0 and `irq_o` is low.
- R2: The status layout is fixed:
  - bit 0 is bus reset, bit 1 is resume, bit 2 is suspend, bit 3 is start-of-frame and bit 4 is pseudo start-of-frame. These come from `bus_evt[0..4]`.
  - bit 5 is the DMA summary.
  - endpoint n receive is bit 8+2n and endpoint n transmit is bit 9+2n.
  - An event pulse sets its bit at the clock edge where the pulse is sampled.
- R3: A set status bit stays set until software clears it.
- R4: Writing to address 0 clears exactly the bits written as 1. Bits written as 0 are unchanged.
- R5: If an event and a write-1 clear of the same bit fall in the same cycle, the bit stays set.
- R6: Reserved positions (bits 6, 7 and 24 to 31 of status and of status enable, and the reason bits at and above DMA_W) read as 0 and ignore writes.
- R7: `irq_o` equals the OR of (status AND enable) as it stood one clock earlier.
- R8: `dma_evt[j]` sets reason bit j. Reason bits are sticky, cleared by writing 1 to address 2, and an event wins over a clear in the same cycle.
- R9: The DMA summary bit sets one cycle after (reason AND reason enable) becomes nonzero. A reason bit that is not enabled never sets the summary.
- R10: Clearing the summary while an enabled reason is still pending makes it read 0 for one cycle and then 1 again. Clearing the reason bits first and the summary bit second leaves the summary at 0.
- R11: The status enable and reason enable registers store written values at addresses 1 and 3, and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_evt | input | 5 | Bus state event pulses (reset, resume, suspend, SOF, pseudo SOF) |
| ep_rx_evt | input | NUM_EP | Endpoint receive event pulses |
| ep_tx_evt | input | NUM_EP | Endpoint transmit event pulses |
| dma_evt | input | DMA_W | DMA cause event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Registered active-high interrupt level |

## Verification
The timing of each result is fixed:

- A status or reason bit can be read right after the edge that samples its event or clear write.
- The DMA summary follows one edge after the reason or reason-enable change.
- `irq_o` follows one edge after the status or enable change.
- A reason event therefore reaches `irq_o` two edges later.

The bench drives inputs just after a falling edge and reads just before the next one. It adds exactly the number of edges listed above before each comparison. A sweep walks every event source through set, clear-with-zeros, clear and enable-driven interrupt, predicting each bit position arithmetically.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int STAT_W    = 32;
    localparam int BUS_EVT_W = 5;
    localparam int DMA_BIT   = 5;
    localparam int EP_BASE   = 8;
    localparam int MAX_EP    = 8;

    typedef enum logic [1:0] {
        REG_STATUS    = 2'd0,
        REG_ENABLE    = 2'd1,
        REG_REASON    = 2'd2,
        REG_REASON_EN = 2'd3
    } reg_sel_e;

    typedef enum logic {
        SUM_IDLE,
        SUM_ACTIVE
    } sum_state_e;

    typedef enum logic {
        LINE_LOW,
        LINE_HIGH
    } line_state_e;

    // Bits of the status word that latch hardware events directly
    function automatic logic [STAT_W-1:0] latch_mask(input int n_ep);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int b = 0; b < BUS_EVT_W; b++) m[b] = 1'b1;
        for (int e = 0; e < 2 * n_ep; e++) m[EP_BASE + e] = 1'b1;
        return m;
    endfunction

    function automatic logic [STAT_W-1:0] low_mask(input int w);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int b = 0; b < w; b++) m[b] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/usb_irq_sticky.sv
module usb_irq_sticky #(
    parameter int          W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= ((q_r & ~clr_i) | set_i) & KEEP;
    end

    assign q_o = q_r;
endmodule

// File: rtl/usb_irq_ctrl_reg.sv
module usb_irq_ctrl_reg #(
    parameter int          W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n)    q_r <= '0;
        else if (we_i) q_r <= d_i & KEEP;
    end

    assign q_o = q_r;
endmodule

// File: rtl/usb_irq_dma_summary.sv
module usb_irq_dma_summary
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic ack_i,
    output logic active_o
);
    sum_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SUM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE:   if (pending_i) state_d = SUM_ACTIVE;  // arm
            SUM_ACTIVE: if (ack_i)     state_d = SUM_IDLE;    // ack
            default:                   state_d = SUM_IDLE;
        endcase
    end

    always_comb begin
        active_o = (state_q == SUM_ACTIVE);
    end
endmodule

// File: rtl/usb_irq_line.sv
module usb_irq_line
    import usb_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_i,
    output logic irq_o
);
    line_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (any_i)  state_d = LINE_HIGH;  // raise
            LINE_HIGH: if (!any_i) state_d = LINE_LOW;   // drop
            default:               state_d = LINE_LOW;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_HIGH);
    end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 8,
    parameter int DMA_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BUS_EVT_W-1:0] bus_evt,
    input  logic [NUM_EP-1:0]    ep_rx_evt,
    input  logic [NUM_EP-1:0]    ep_tx_evt,
    input  logic [DMA_W-1:0]     dma_evt,
    input  logic                 bus_wr,
    input  logic [1:0]           bus_addr,
    input  logic [STAT_W-1:0]    bus_wdata,
    output logic [STAT_W-1:0]    bus_rdata,
    output logic                 irq_o
);
    localparam logic [STAT_W-1:0] LATCH_KEEP  = latch_mask(NUM_EP);
    localparam logic [STAT_W-1:0] DMA_ONE     = STAT_W'(1) << DMA_BIT;
    localparam logic [STAT_W-1:0] ENABLE_KEEP = LATCH_KEEP | DMA_ONE;
    localparam logic [STAT_W-1:0] REASON_KEEP = low_mask(DMA_W);

    reg_sel_e sel;
    logic [STAT_W-1:0] event_vec, status_clr, reason_clr, reason_set;
    logic [STAT_W-1:0] latched_q, enable_q, reason_q, reason_en_q, status_view;
    logic              we_enable, we_reason_en, dma_ack, dma_pending, dma_active;

    assign sel = reg_sel_e'(bus_addr);

    // Event vector assembly
    always_comb begin
        event_vec = '0;
        event_vec[BUS_EVT_W-1:0] = bus_evt;
        for (int n = 0; n < NUM_EP; n++) begin
            event_vec[EP_BASE + 2*n]     = ep_rx_evt[n];
            event_vec[EP_BASE + 2*n + 1] = ep_tx_evt[n];
        end
        reason_set = '0;
        reason_set[DMA_W-1:0] = dma_evt;
    end

    always_comb begin
        status_clr   = (bus_wr && sel == REG_STATUS) ? bus_wdata : '0;
        reason_clr   = (bus_wr && sel == REG_REASON) ? bus_wdata : '0;
        we_enable    = bus_wr && sel == REG_ENABLE;
        we_reason_en = bus_wr && sel == REG_REASON_EN;
        dma_ack      = status_clr[DMA_BIT];
        dma_pending  = |(reason_q & reason_en_q);
    end

    usb_irq_sticky #(.W(STAT_W), .KEEP(LATCH_KEEP)) u_status (
        .clk(clk), .rst_n(rst_n), .set_i(event_vec), .clr_i(status_clr), .q_o(latched_q)
    );

    usb_irq_sticky #(.W(STAT_W), .KEEP(REASON_KEEP)) u_reason (
        .clk(clk), .rst_n(rst_n), .set_i(reason_set), .clr_i(reason_clr), .q_o(reason_q)
    );

    usb_irq_ctrl_reg #(.W(STAT_W), .KEEP(ENABLE_KEEP)) u_enable (
        .clk(clk), .rst_n(rst_n), .we_i(we_enable), .d_i(bus_wdata), .q_o(enable_q)
    );

    usb_irq_ctrl_reg #(.W(STAT_W), .KEEP(REASON_KEEP)) u_reason_en (
        .clk(clk), .rst_n(rst_n), .we_i(we_reason_en), .d_i(bus_wdata), .q_o(reason_en_q)
    );

    usb_irq_dma_summary u_dma_sum (
        .clk(clk), .rst_n(rst_n), .pending_i(dma_pending), .ack_i(dma_ack), .active_o(dma_active)
    );

    always_comb begin
        status_view = latched_q;
        status_view[DMA_BIT] = dma_active;
    end

    usb_irq_line u_line (
        .clk(clk), .rst_n(rst_n), .any_i(|(status_view & enable_q)), .irq_o(irq_o)
    );

    always_comb begin
        unique case (sel)
            REG_STATUS:    bus_rdata = status_view;
            REG_ENABLE:    bus_rdata = enable_q;
            REG_REASON:    bus_rdata = reason_q;
            REG_REASON_EN: bus_rdata = reason_en_q;
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [4:0]  bus_evt,
    input logic [31:0] status,
    input logic [31:0] enable,
    input logic [31:0] reason,
    input logic [31:0] reason_en,
    input logic        dma_sum,
    input logic        irq
);
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[31:24] == 8'h00 && status[7:6] == 2'b00 && enable[31:24] == 8'h00);

    // R7
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(status & enable)));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_evt[0] |=> status[0]);

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] && !(bus_wr && bus_addr == 2'd0 && bus_wdata[2]) |=> status[2]);

    // R4
    clear_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == 2'd0 && bus_wdata[1] && !bus_evt[1] |=> !status[1]);

    // R9
    summary_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_sum) |-> $past(|(reason & reason_en)));
endmodule

bind usb_irq_status usb_irq_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_evt(bus_evt), .status(status_view),
    .enable(enable_q), .reason(reason_q), .reason_en(reason_en_q),
    .dma_sum(dma_active), .irq(irq_o)
);

// File: tb/usb_irq_status_test.sv
module usb_irq_status_test;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_EP = 8;
    localparam int DMA_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [4:0]        bus_evt = '0;
    logic [NUM_EP-1:0] ep_rx_evt = '0, ep_tx_evt = '0;
    logic [DMA_W-1:0]  dma_evt = '0;
    logic              bus_wr = 1'b0;
    logic [1:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o;

    int n_tests = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_status #(.NUM_EP(NUM_EP), .DMA_W(DMA_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_evt(bus_evt), .ep_rx_evt(ep_rx_evt),
        .ep_tx_evt(ep_tx_evt), .dma_evt(dma_evt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    // Drive source k: 0..4 bus events, then endpoint rx/tx alternating
    task automatic drive_src(input int k, input logic v);
        if (k < 5) bus_evt[k] = v;
        else if (((k - 5) % 2) == 0) ep_rx_evt[(k - 5) / 2] = v;
        else ep_tx_evt[(k - 5) / 2] = v;
    endtask

    function automatic int src_pos(input int k);
        return (k < 5) ? k : 8 + (k - 5);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset reg", v, 32'h0);
        end
        check("R1 reset irq", {31'b0, irq_o}, 32'h0);

        // Sweep all hardware event sources
        for (int k = 0; k < 5 + 2*NUM_EP; k++) begin
            logic [31:0] bitv;
            bitv = 32'h1 << src_pos(k);
            drive_src(k, 1'b1);
            tick();
            drive_src(k, 1'b0);
            rd(2'd0, v);
            check("R2 event sets its bit", v, bitv);
            tick(); tick();
            rd(2'd0, v);
            check("R3 bit sticky", v, bitv);
            check("R7 irq low while masked", {31'b0, irq_o}, 32'h0);
            wr(2'd1, bitv);
            tick();
            check("R7 irq high when enabled", {31'b0, irq_o}, 32'h1);
            wr(2'd0, ~bitv);
            rd(2'd0, v);
            check("R4 zeros leave bit", v, bitv);
            wr(2'd0, bitv);
            rd(2'd0, v);
            check("R4 one clears bit", v, 32'h0);
            tick();
            check("R7 irq drops", {31'b0, irq_o}, 32'h0);
            wr(2'd1, 32'h0);
        end

        // R5 set wins over clear
        bus_evt[0] = 1'b1;
        tick();
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h1;
        tick();
        bus_wr = 1'b0; bus_wdata = '0; bus_evt[0] = 1'b0;
        rd(2'd0, v);
        check("R5 set wins", v, 32'h1);
        wr(2'd0, 32'h1);
        rd(2'd0, v);
        check("R5 clear afterwards", v, 32'h0);

        // R6 / R11 reserved bits and enable readback
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v);
        check("R6 enable reserved", v, 32'h00FF_FF3F);
        wr(2'd1, 32'h0001_2345);
        rd(2'd1, v);
        check("R11 enable readback", v, 32'h0001_2305);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, v);
        check("R6 status write ignored", v, 32'h0);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, v);
        check("R11 reason enable readback", v, 32'h0000_000F);
        wr(2'd3, 32'h0);

        // DMA reason sweep
        for (int j = 0; j < DMA_W; j++) begin
            dma_evt[j] = 1'b1;
            tick();
            dma_evt[j] = 1'b0;
            rd(2'd2, v);
            check("R8 reason bit set", v, 32'h1 << j);
            tick(); tick();
            rd(2'd0, v);
            check("R9 disabled reason no summary", v, 32'h0);
            wr(2'd3, 32'h1 << j);
            rd(2'd0, v);
            check("R9 summary not yet", v, 32'h0);
            tick();
            rd(2'd0, v);
            check("R9 summary set", v, 32'h20);
            wr(2'd1, 32'h20);
            tick();
            check("R7 irq from dma", {31'b0, irq_o}, 32'h1);
            wr(2'd0, 32'h20);
            rd(2'd0, v);
            check("R10 early ack reads 0", v, 32'h0);
            tick();
            rd(2'd0, v);
            check("R10 early ack resets", v, 32'h20);
            // R8 set wins over reason clear
            dma_evt[j] = 1'b1;
            bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 32'h1 << j;
            tick();
            bus_wr = 1'b0; bus_wdata = '0; dma_evt[j] = 1'b0;
            rd(2'd2, v);
            check("R8 reason set wins", v, 32'h1 << j);
            wr(2'd2, 32'h1 << j);
            rd(2'd2, v);
            check("R8 reason cleared", v, 32'h0);
            wr(2'd0, 32'h20);
            tick();
            rd(2'd0, v);
            check("R10 ordered clear stays 0", v, 32'h0);
            tick();
            check("R7 irq low after dma clear", {31'b0, irq_o}, 32'h0);
            wr(2'd1, 32'h0);
            wr(2'd3, 32'h0);
        end

        // R6 reason reserved bits
        wr(2'd2, 32'hFFFF_FFFF);
        rd(2'd2, v);
        check("R6 reason reserved", v, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule